// File: doc/BRIEF.md
# Data-Space Decoder with External SRAM Sequencer

This block sits on the load/store port of a small CPU and routes each 16-bit data address to one of five regions. The low end of the space holds the register file, the standard I/O window and the extended I/O window, each reached through a select line. Internal SRAM comes next, and a model of it is included. Every address above internal SRAM belongs to external SRAM. Internal accesses finish in the cycle the request is presented. External accesses go through a sequencer that drives an address bus, a shared data bus and active-low read and write strobes, and holds the CPU with a stall output for the extra cycles.

A three-bit configuration port sets an enable for the external region and a wait-state count from 0 to 3. An external access costs one cycle plus the wait-state count. A stack push or pop of several bytes pays that cost once for each byte. When the enable is clear, accesses to the external region are dropped without any bus activity.

Top module: `dspace_xmem_ctrl`

## Requirements
- R1: Address decode: 0x0000–0x001F raises `rf_sel`, 0x0020–0x005F raises `io_sel`, and 0x0060–0x01FF raises `xio_sel`, each in the same cycle as `cpu_req`. A read from any of these three regions returns `periph_rdata`.
- R2: Internal SRAM covers 0x0200 up to 0x0200+ISRAM_BYTES-1 (0x11FF by default). It is read and written with no stall. Read data appears on `cpu_rdata` from the cycle after the completing clock edge, and this holds for every region.
- R3: No internal access asserts `cpu_stall`, `xm_rd_n` or `xm_wr_n`, either in the access cycle or in the cycle after it.
- R4: Writing the configuration port (`cfg_we`) loads bit 0 as the external enable and bits 2:1 as the wait-state count N. Both reset to 0.
- R5: With the enable clear, an access to an external address is ignored. A read returns 0x00, no strobe is driven, no stall is raised and no byte is written.
- R6: An external read stalls the CPU for 1+N cycles and holds `xm_rd_n` low for 1+N cycles with `xm_addr` stable. Data is sampled in the last strobe cycle, which is also the first cycle with the stall released.
- R7: An external write holds `xm_wr_n` low for 1+N cycles and stalls the CPU for 1+N cycles. The bus carries the write byte while the strobe is low and is released otherwise.
- R8: Successive external accesses, such as a three-byte stack push, each cost 1+N stall cycles, so three bytes cost 3(1+N).
- R9: The wait-state count is captured when an external access starts. A configuration write during the access applies from the next access on.
- R10: The read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held while stalled |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Data-space byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered |
| cpu_stall | output | 1 | Hold the CPU this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Bit 0 enable, bits 2:1 wait states |
| periph_rdata | input | 8 | Read data from register file and I/O |
| rf_sel | output | 1 | Register-file select |
| io_sel | output | 1 | Standard I/O select |
| xio_sel | output | 1 | Extended I/O select |
| xm_addr | output | 16 | External address bus |
| xm_data | inout | 8 | External data bus |
| xm_rd_n | output | 1 | External read strobe, active low |
| xm_wr_n | output | 1 | External write strobe, active low |

## Verification
Addresses on each side of every region edge (0x001F/0x0020, 0x005F/0x0060, 0x01FF/0x0200, 0x11FF/0x1200) show whether the decode is off by one. External reads are repeated at all four wait-state settings, which separates a cost of 1+N from a fixed or doubled penalty. Access to the external region is tried with the enable clear and then set, which shows whether the gating works. A three-byte write burst shows that the cost adds up per byte. A configuration change made in the middle of an access shows whether the wait-state count is latched at the start.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned WS_W   = 2;

    localparam int unsigned IO_BASE    = 32;
    localparam int unsigned XIO_BASE   = 96;
    localparam int unsigned ISRAM_BASE = 512;

    typedef enum logic [2:0] {
        RG_RF,
        RG_IO,
        RG_XIO,
        RG_ISRAM,
        RG_EXT
    } region_e;

    typedef enum logic {
        XS_IDLE,
        XS_ACC
    } xstate_e;
endpackage

// File: rtl/dspace_region_dec.sv
module dspace_region_dec
    import dspace_pkg::*;
#(
    parameter int unsigned AW          = ADDR_W,
    parameter int unsigned ISRAM_BYTES = 4096
) (
    input  logic [AW-1:0] addr,
    output region_e       region
);
    localparam logic [AW:0] IO_B    = (AW+1)'(IO_BASE);
    localparam logic [AW:0] XIO_B   = (AW+1)'(XIO_BASE);
    localparam logic [AW:0] ISRAM_B = (AW+1)'(ISRAM_BASE);
    localparam logic [AW:0] EXT_B   = (AW+1)'(ISRAM_BASE + ISRAM_BYTES);

    logic [AW:0] a_wide;

    always_comb begin
        a_wide = {1'b0, addr};
        if (a_wide < IO_B) begin
            region = RG_RF;
        end else if (a_wide < XIO_B) begin
            region = RG_IO;
        end else if (a_wide < ISRAM_B) begin
            region = RG_XIO;
        end else if (a_wide < EXT_B) begin
            region = RG_ISRAM;
        end else begin
            region = RG_EXT;
        end
    end
endmodule

// File: rtl/isram_model.sv
module isram_model #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned DW    = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import dspace_pkg::*;
#(
    parameter int unsigned AW  = ADDR_W,
    parameter int unsigned DW  = DATA_W,
    parameter int unsigned WSW = WS_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           start_we,
    input  logic [AW-1:0]  start_addr,
    input  logic [DW-1:0]  start_wdata,
    input  logic [WSW-1:0] wait_cnt,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_oe,
    output logic           rd_n,
    output logic           wr_n,
    output logic           busy,
    output logic           last,
    output logic           stall
);
    typedef struct packed {
        xstate_e        st;
        logic [WSW-1:0] cnt;
        logic           we;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            XS_IDLE: begin
                if (start) begin
                    d.st    = XS_ACC;
                    d.cnt   = wait_cnt;
                    d.we    = start_we;
                    d.addr  = start_addr;
                    d.wdata = start_wdata;
                end
            end
            XS_ACC: begin
                if (q.cnt == '0) begin
                    d.st = XS_IDLE;
                end else begin
                    d.cnt = q.cnt - WSW'(1);
                end
            end
            default: d.st = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: XS_IDLE, cnt: '0, we: 1'b0, addr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st == XS_ACC);
    assign last     = busy && (q.cnt == '0);
    assign stall    = (!busy && start) || (busy && !last);
    assign rd_n     = !(busy && !q.we);
    assign wr_n     = !(busy && q.we);
    assign bus_oe   = busy && q.we;
    assign bus_addr = q.addr;
    assign bus_dout = q.wdata;
endmodule

// File: rtl/dspace_xmem_ctrl.sv
module dspace_xmem_ctrl
    import dspace_pkg::*;
#(
    parameter int unsigned ISRAM_BYTES = 4096,
    parameter int unsigned MODEL_IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              cfg_we,
    input  logic [WS_W:0]     cfg_wdata,
    input  logic [DATA_W-1:0] periph_rdata,
    output logic              rf_sel,
    output logic              io_sel,
    output logic              xio_sel,
    output logic [ADDR_W-1:0] xm_addr,
    inout  wire  [DATA_W-1:0] xm_data,
    output logic              xm_rd_n,
    output logic              xm_wr_n
);
    localparam logic [ADDR_W-1:0] ISRAM_BASE_A = ADDR_W'(ISRAM_BASE);

    typedef struct packed {
        logic              cfg_en;
        logic [WS_W-1:0]   cfg_ws;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t q, d;

    region_e              region;
    logic                 seq_busy;
    logic                 seq_last;
    logic                 seq_stall;
    logic                 seq_oe;
    logic [DATA_W-1:0]    seq_dout;
    logic                 seq_start;
    logic                 local_ok;
    logic                 sram_wr;
    logic [MODEL_IDX_W-1:0] sram_idx;
    logic [DATA_W-1:0]    sram_rdata;
    logic                 cfg_en_q;
    logic [WS_W-1:0]      cfg_ws_q;

    dspace_region_dec #(
        .AW          (ADDR_W),
        .ISRAM_BYTES (ISRAM_BYTES)
    ) u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    assign local_ok  = cpu_req && !seq_busy;
    assign seq_start = local_ok && (region == RG_EXT) && q.cfg_en;

    xmem_seq #(
        .AW  (ADDR_W),
        .DW  (DATA_W),
        .WSW (WS_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (seq_start),
        .start_we    (cpu_we),
        .start_addr  (cpu_addr),
        .start_wdata (cpu_wdata),
        .wait_cnt    (q.cfg_ws),
        .bus_addr    (xm_addr),
        .bus_dout    (seq_dout),
        .bus_oe      (seq_oe),
        .rd_n        (xm_rd_n),
        .wr_n        (xm_wr_n),
        .busy        (seq_busy),
        .last        (seq_last),
        .stall       (seq_stall)
    );

    assign xm_data = seq_oe ? seq_dout : 'z;

    assign sram_wr  = local_ok && cpu_we && (region == RG_ISRAM);
    assign sram_idx = cpu_addr[MODEL_IDX_W-1:0] - ISRAM_BASE_A[MODEL_IDX_W-1:0];

    isram_model #(
        .IDX_W (MODEL_IDX_W),
        .DW    (DATA_W)
    ) u_sram (
        .clk   (clk),
        .wr_en (sram_wr),
        .idx   (sram_idx),
        .wdata (cpu_wdata),
        .rdata (sram_rdata)
    );

    always_comb begin
        d = q;
        if (cfg_we) begin
            d.cfg_en = cfg_wdata[0];
            d.cfg_ws = cfg_wdata[WS_W:1];
        end
        if (seq_last && !xm_rd_n) begin
            d.rdata = xm_data;
        end else if (local_ok && !cpu_we) begin
            case (region)
                RG_RF, RG_IO, RG_XIO: d.rdata = periph_rdata;
                RG_ISRAM:             d.rdata = sram_rdata;
                RG_EXT: begin
                    if (!q.cfg_en) begin
                        d.rdata = '0;
                    end
                end
                default: d.rdata = q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{cfg_en: 1'b0, cfg_ws: '0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign cpu_rdata = q.rdata;
    assign cpu_stall = seq_stall;
    assign rf_sel    = local_ok && (region == RG_RF);
    assign io_sel    = local_ok && (region == RG_IO);
    assign xio_sel   = local_ok && (region == RG_XIO);
    assign cfg_en_q  = q.cfg_en;
    assign cfg_ws_q  = q.cfg_ws;
endmodule

// File: rtl/dspace_xmem_chk.sv
module dspace_xmem_chk
    import dspace_pkg::*;
#(
    parameter int unsigned ISRAM_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_stall,
    input logic [ADDR_W-1:0] xm_addr,
    input logic              xm_rd_n,
    input logic              xm_wr_n,
    input logic              cfg_en,
    input logic [WS_W-1:0]   cfg_ws
);
    localparam logic [ADDR_W:0] EXT_B = (ADDR_W+1)'(ISRAM_BASE + ISRAM_BYTES);

    logic            strb;
    logic            strb_q;
    logic            is_int;
    logic [2:0]      run;
    logic [WS_W-1:0] ws_lat;

    assign strb   = !xm_rd_n || !xm_wr_n;
    assign is_int = ({1'b0, cpu_addr} < EXT_B);

    // R6 / R9: strobe length equals 1+N with N taken at access start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            run    <= '0;
            ws_lat <= '0;
        end else begin
            strb_q <= strb;
            if (cpu_stall && !strb) begin
                ws_lat <= cfg_ws;
            end
            if (strb) begin
                run <= run + 3'd1;
            end else begin
                run <= '0;
            end
            if (strb_q && !strb) begin
                a_r6_strobe_len: assert (run == ({1'b0, ws_lat} + 3'd1))
                    else $error("strobe length %0d, wait states %0d", run, ws_lat);
            end
        end
    end

    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xm_rd_n && !xm_wr_n));

    a_r3_internal_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && is_int && !strb) |-> !cpu_stall);

    a_r3_internal_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && is_int && !strb && !cpu_stall) |=> !strb);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !is_int && !cfg_en && !strb) |-> (!cpu_stall ##1 !strb));

    a_r6_strobe_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb) |-> $past(cpu_stall));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && strb_q) |-> $stable(xm_addr));

    a_r6_release_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !cpu_stall) |=> !strb);
endmodule

bind dspace_xmem_ctrl dspace_xmem_chk #(
    .ISRAM_BYTES (ISRAM_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_stall (cpu_stall),
    .xm_addr   (xm_addr),
    .xm_rd_n   (xm_rd_n),
    .xm_wr_n   (xm_wr_n),
    .cfg_en    (cfg_en_q),
    .cfg_ws    (cfg_ws_q)
);

// File: tb/dspace_xmem_ctrl_bench.sv
module dspace_xmem_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PERIPH_VAL = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wdata = '0;
    logic [7:0]  periph_rdata = PERIPH_VAL;
    logic        rf_sel, io_sel, xio_sel;
    logic [15:0] xm_addr;
    wire  [7:0]  xm_data;
    logic        xm_rd_n, xm_wr_n;

    logic [7:0]  ext_mem [256];
    int          rd_cyc = 0;
    int          wr_cyc = 0;
    int          wr_bad = 0;
    logic [7:0]  wr_expect = '0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dspace_xmem_ctrl u_dspace_xmem_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_stall    (cpu_stall),
        .cfg_we       (cfg_we),
        .cfg_wdata    (cfg_wdata),
        .periph_rdata (periph_rdata),
        .rf_sel       (rf_sel),
        .io_sel       (io_sel),
        .xio_sel      (xio_sel),
        .xm_addr      (xm_addr),
        .xm_data      (xm_data),
        .xm_rd_n      (xm_rd_n),
        .xm_wr_n      (xm_wr_n)
    );

    // external SRAM model
    assign xm_data = xm_rd_n ? 8'hzz : ext_mem[xm_addr[7:0]];

    always @(posedge clk) begin
        if (!xm_wr_n) ext_mem[xm_addr[7:0]] <= xm_data;
    end

    always @(negedge clk) begin
        if (!xm_rd_n) rd_cyc++;
        if (!xm_wr_n) begin
            wr_cyc++;
            if (xm_data !== wr_expect) wr_bad++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic [1:0] ws);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = {ws, en};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic we, input logic [15:0] a, input logic [7:0] wd,
                          output logic [7:0] rd, output int stalls);
        rd_cyc = 0;
        wr_cyc = 0;
        wr_bad = 0;
        wr_expect = wd;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = wd;
        stalls = 0;
        #1;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we = 1'b0;
        rd = cpu_rdata;
    endtask

    task automatic t_reset;
        #1;
        check("R4 reset stall", cpu_stall, 0);
        check("R4 reset rd_n", xm_rd_n, 1);
        check("R4 reset wr_n", xm_wr_n, 1);
        check("R2 reset rdata", cpu_rdata, 0);
    endtask

    task automatic region_probe(input logic [15:0] a, input logic [2:0] exp_sel, input string req);
        logic [7:0] rd;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = 1'b0;
        cpu_addr = a;
        #1;
        check(req, {29'd0, rf_sel, io_sel, xio_sel}, {29'd0, exp_sel});
        check("R3 probe no stall", cpu_stall, 0);
        @(negedge clk);
        cpu_req = 1'b0;
        rd = cpu_rdata;
        if (exp_sel != 3'b000) check("R1 periph rdata", rd, PERIPH_VAL);
    endtask

    task automatic t_decode;
        region_probe(16'h0000, 3'b100, "R1 rf low");
        region_probe(16'h001F, 3'b100, "R1 rf top");
        region_probe(16'h0020, 3'b010, "R1 io low");
        region_probe(16'h005F, 3'b010, "R1 io top");
        region_probe(16'h0060, 3'b001, "R1 xio low");
        region_probe(16'h01FF, 3'b001, "R1 xio top");
        region_probe(16'h0200, 3'b000, "R1 sram not io");
    endtask

    task automatic t_internal_sram;
        logic [7:0] rd;
        int st;
        access(1'b1, 16'h0200, 8'h3C, rd, st);
        check("R2 sram write stall", st, 0);
        check("R3 sram write no strobe", wr_cyc + rd_cyc, 0);
        access(1'b1, 16'h11FF, 8'h96, rd, st);
        check("R3 sram top write no strobe", wr_cyc + rd_cyc, 0);
        access(1'b0, 16'h0200, 8'h00, rd, st);
        check("R2 sram read base", rd, 8'h3C);
        check("R2 sram read stall", st, 0);
        access(1'b0, 16'h11FF, 8'h00, rd, st);
        check("R2 sram read top", rd, 8'h96);
        check("R3 sram read no strobe", rd_cyc, 0);
    endtask

    task automatic t_disabled;
        logic [7:0] rd;
        int st;
        set_cfg(1'b0, 2'd2);
        access(1'b0, 16'h1200, 8'h00, rd, st);
        check("R5 disabled read data", rd, 8'h00);
        check("R5 disabled read stall", st, 0);
        check("R5 disabled read strobe", rd_cyc, 0);
        access(1'b1, 16'h1201, 8'hEE, rd, st);
        check("R5 disabled write strobe", wr_cyc, 0);
        check("R5 disabled write stall", st, 0);
        check("R5 disabled write mem", ext_mem[8'h01], 8'h01 ^ 8'hA5);
    endtask

    task automatic t_ext_reads;
        logic [7:0] rd;
        int st;
        for (int ws = 0; ws < 4; ws++) begin
            set_cfg(1'b1, ws[1:0]);
            access(1'b0, 16'h1234 + 16'(ws), 8'h00, rd, st);
            check($sformatf("R6 read ws%0d stall", ws), st, 1 + ws);
            check($sformatf("R6 read ws%0d strobe", ws), rd_cyc, 1 + ws);
            check($sformatf("R6 read ws%0d data", ws), rd, (8'h34 + 8'(ws)) ^ 8'hA5);
        end
        set_cfg(1'b1, 2'd0);
        access(1'b0, 16'hFFFF, 8'h00, rd, st);
        check("R6 top address data", rd, 8'hFF ^ 8'hA5);
        access(1'b0, 16'h1200, 8'h00, rd, st);
        check("R6 ext base data", rd, 8'h00 ^ 8'hA5);
        check("R4 enable now set stall", st, 1);
    endtask

    task automatic t_ext_write;
        logic [7:0] rd;
        int st;
        set_cfg(1'b1, 2'd2);
        access(1'b1, 16'h4050, 8'h5E, rd, st);
        check("R7 write stall", st, 3);
        check("R7 write strobe", wr_cyc, 3);
        check("R7 write bus data", wr_bad, 0);
        check("R7 write mem", ext_mem[8'h50], 8'h5E);
        check("R10 no read strobe in write", rd_cyc, 0);
    endtask

    task automatic t_stack_burst;
        logic [7:0] rd;
        int st;
        int total = 0;
        set_cfg(1'b1, 2'd1);
        for (int i = 0; i < 3; i++) begin
            access(1'b1, 16'hF0FD + 16'(i), 8'h10 + 8'(i), rd, st);
            total += st;
        end
        check("R8 three-byte push cost", total, 6);
        check("R8 push bytes", {ext_mem[8'hFD], ext_mem[8'hFE], ext_mem[8'hFF]}, 24'h101112);
    endtask

    task automatic t_ws_latch;
        logic [7:0] rd;
        int st;
        set_cfg(1'b1, 2'd3);
        rd_cyc = 0;
        @(negedge clk);
        cpu_req = 1'b1;
        cpu_we = 1'b0;
        cpu_addr = 16'h2222;
        cfg_we = 1'b1;
        cfg_wdata = {2'd0, 1'b1};
        st = 0;
        #1;
        while (cpu_stall) begin
            st++;
            @(negedge clk);
            cfg_we = 1'b0;
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cfg_we = 1'b0;
        check("R9 latched ws stall", st, 4);
        check("R9 latched ws strobe", rd_cyc, 4);
        access(1'b0, 16'h2223, 8'h00, rd, st);
        check("R9 new ws next access", st, 1);
        check("R9 data", rd, 8'h23 ^ 8'hA5);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) ext_mem[i] = 8'(i) ^ 8'hA5;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_decode();
        t_internal_sram();
        t_disabled();
        t_ext_reads();
        t_ext_write();
        t_stack_burst();
        t_ws_latch();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule